// File: doc/BRIEF.md
# Page-Organised Flash Array Emulator

This block models a small flash array inside ordinary on-chip storage, so that a flash controller can be developed and exercised before real flash parts are available. Commands arrive on a valid/ready port: read a page, program a page, or erase a block. Page data moves one byte per cycle through an internal page buffer. Program data streams in over a byte input. Read data streams out over a byte output. A `done` pulse with a two-bit status code closes every command.

The model follows flash rules rather than RAM rules. A program can only pull bits from 1 to 0, so the stored page becomes the AND of its old and new contents. Only erase brings bits back to 1, and it always clears a whole block, spare bytes included. Within a block, pages are programmed in ascending order. Each page accepts a bounded number of partial programs between erases, and that bound depends on a cell-mode input. A command that breaks a rule is refused with a status code and leaves the stored array as it was.

The default instance has 4 blocks of 32 pages. Each page holds 512 data bytes followed by 16 spare bytes. A page address is `block * PAGES_PER_BLOCK + page`. The address bus carries one extra bit so that out-of-range addresses can be expressed.

Top module: `fe_flash_emu`

## Requirements
- R1: After reset, every page of every block reads back as all 0xFF bytes, data and spare alike, with status 0 (OK).
- R2: A read streams the page as PAGE_BYTES bytes, byte 0 first; bytes DATA_BYTES and above are the spare area. An accepted program stores the old page contents ANDed bytewise with the loaded bytes, so bits already at 0 stay 0.
- R3: An erase (cmd_op bit 1 set, so codes 2 and 3) returns every byte of every page in the addressed block to 0xFF. Pages of other blocks are unchanged.
- R4: A program to a page whose index within its block is lower than the highest page programmed in that block since its last erase returns status 1 and changes nothing. A program to that same highest page, or to a higher page, is allowed.
- R5: With mlc_mode low, a page accepts 4 programs between erases; with mlc_mode high, it accepts 1. The mode is sampled when each program completes. A program beyond the limit returns status 2 and changes nothing.
- R6: An erase clears the program counts of all pages in its block and forgets that block's highest-programmed page. Any page of the block may then be programmed again.
- R7: A command of any kind whose address is at least NUM_BLOCKS*PAGES_PER_BLOCK completes with status 3, has no data phase, and changes nothing.
- R8: Command timing is fixed, counting from the clock edge at which the command is accepted:
  - cmd_ready is high only when the block is idle.
  - For a read, rd_valid is high for exactly PAGE_BYTES consecutive cycles, starting two edges after acceptance, and done follows one cycle after the last byte.
  - An out-of-range command raises done after one edge.
  - An erase raises done after two edges.
  - A program raises done two edges after its last byte is taken.
- R9: When a program breaks both the ordering rule and the count limit, the status is 1 (ordering).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mlc_mode | input | 1 | 0: up to 4 programs per page; 1: a single program per page |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Idle; a command is accepted when cmd_valid is also high |
| cmd_op | input | 2 | 0 read, 1 program, 2 or 3 erase |
| cmd_addr | input | ADDR_W | Flat page address (block * PAGES_PER_BLOCK + page) |
| wr_valid | input | 1 | Program data byte strobe |
| wr_byte | input | 8 | Program data byte |
| rd_valid | output | 1 | Read data byte strobe |
| rd_byte | output | 8 | Read data byte |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Completion code: 0 OK, 1 order, 2 limit, 3 range; held until the next completion |

## Verification
The assertions assume that a controller issues commands only while cmd_ready is high. They also assume that wr_valid is driven only during the data phase of a program that has been accepted. The stimulus keeps within these assumptions: each command waits for cmd_ready, and program bytes are driven only after an in-range program has been accepted. The random phase draws addresses, operations and cell mode from a fixed seed, including out-of-range addresses. Rejected orders and limits arise naturally from random page choices, and a bench model predicts every status and every byte read back.

// File: rtl/fe_pkg.sv
package fe_pkg;

  typedef enum logic [1:0] {
    ST_OK    = 2'd0,
    ST_ORDER = 2'd1,
    ST_LIMIT = 2'd2,
    ST_RANGE = 2'd3
  } fe_status_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD_FETCH,
    S_RD_OUT,
    S_LOAD,
    S_COMMIT,
    S_ERASE,
    S_DONE
  } fe_state_e;

  localparam logic [2:0] SLC_LIMIT = 3'd4;
  localparam logic [2:0] MLC_LIMIT = 3'd1;

endpackage

// File: rtl/fe_page_buf.sv
module fe_page_buf #(
  parameter int PAGE_BYTES = 528,
  localparam int PAGE_BITS = PAGE_BYTES * 8,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic                 clk,
  input  logic                 load_en,
  input  logic [PAGE_BITS-1:0] load_word,
  input  logic                 byte_en,
  input  logic [IDX_W-1:0]     byte_idx,
  input  logic [7:0]           byte_in,
  output logic [PAGE_BITS-1:0] word,
  output logic [7:0]           byte_out
);

  logic [PAGE_BITS-1:0] word_q, word_d;
  logic                 word_en;

  assign word_en = load_en | byte_en;

  always_comb begin
    word_d = word_q;
    if (load_en) begin
      word_d = load_word;
    end else if (byte_en) begin
      word_d[{byte_idx, 3'b000} +: 8] = byte_in;
    end
  end

  // datapath register: no reset, the control path qualifies every use
  always_ff @(posedge clk) begin
    if (word_en) word_q <= word_d;
  end

  assign word     = word_q;
  assign byte_out = word_q[{byte_idx, 3'b000} +: 8];

endmodule

// File: rtl/fe_page_store.sv
module fe_page_store #(
  parameter int NUM_BLOCKS      = 4,
  parameter int PAGES_PER_BLOCK = 32,
  parameter int PAGE_BITS       = 4224,
  localparam int TOTAL_PAGES    = NUM_BLOCKS * PAGES_PER_BLOCK,
  localparam int ROW_AW         = $clog2(TOTAL_PAGES),
  localparam int BLK_AW         = $clog2(NUM_BLOCKS),
  localparam int PAGE_AW        = $clog2(PAGES_PER_BLOCK)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ROW_AW-1:0]    rd_addr,
  output logic [PAGE_BITS-1:0] rd_word,
  input  logic                 wr_en,
  input  logic [ROW_AW-1:0]    wr_addr,
  input  logic [PAGE_BITS-1:0] wr_word,
  input  logic                 erase_en,
  input  logic [BLK_AW-1:0]    erase_blk
);

  logic [PAGE_BITS-1:0]   cells [TOTAL_PAGES];
  logic [TOTAL_PAGES-1:0] written_q, written_d;
  logic [PAGE_BITS-1:0]   cur_word;

  // a page never programmed since reset or erase reads as all ones
  assign rd_word  = written_q[rd_addr] ? cells[rd_addr] : '1;
  assign cur_word = written_q[wr_addr] ? cells[wr_addr] : '1;

  always_comb begin
    written_d = written_q;
    if (wr_en) written_d[wr_addr] = 1'b1;
    if (erase_en) begin
      for (int p = 0; p < PAGES_PER_BLOCK; p++) begin
        written_d[int'(erase_blk) * PAGES_PER_BLOCK + p] = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) written_q <= '0;
    else if (wr_en | erase_en) written_q <= written_d;
  end

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_addr] <= cur_word & wr_word;
  end

  // R2
  store_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> written_q[$past(wr_addr)]);

  // R3
  erase_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> !written_q[{$past(erase_blk), PAGE_AW'(0)}]);

  // R8
  op_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && erase_en));

endmodule

// File: rtl/fe_rule_check.sv
module fe_rule_check
  import fe_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int PAGES_PER_BLOCK = 32,
  localparam int TOTAL_PAGES    = NUM_BLOCKS * PAGES_PER_BLOCK,
  localparam int ROW_AW         = $clog2(TOTAL_PAGES),
  localparam int BLK_AW         = $clog2(NUM_BLOCKS),
  localparam int PAGE_AW        = $clog2(PAGES_PER_BLOCK)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mlc_mode,
  input  logic [ROW_AW-1:0] row,
  output fe_status_e        verdict,
  input  logic              commit_en,
  input  logic              erase_en,
  input  logic [BLK_AW-1:0] erase_blk
);

  logic [2:0]         cnt_q  [TOTAL_PAGES];
  logic [2:0]         cnt_d  [TOTAL_PAGES];
  logic               hiv_q  [NUM_BLOCKS];
  logic               hiv_d  [NUM_BLOCKS];
  logic [PAGE_AW-1:0] hip_q  [NUM_BLOCKS];
  logic [PAGE_AW-1:0] hip_d  [NUM_BLOCKS];

  logic [BLK_AW-1:0]  blk;
  logic [PAGE_AW-1:0] pg;
  logic [2:0]         limit;

  assign blk   = row[ROW_AW-1 -: BLK_AW];
  assign pg    = row[PAGE_AW-1:0];
  assign limit = mlc_mode ? MLC_LIMIT : SLC_LIMIT;

  // ordering is checked before the count limit
  always_comb begin
    if (hiv_q[blk] && (pg < hip_q[blk])) verdict = ST_ORDER;
    else if (cnt_q[row] >= limit)         verdict = ST_LIMIT;
    else                                  verdict = ST_OK;
  end

  always_comb begin
    cnt_d = cnt_q;
    hiv_d = hiv_q;
    hip_d = hip_q;
    if (commit_en) begin
      cnt_d[row] = cnt_q[row] + 3'd1;
      hiv_d[blk] = 1'b1;
      hip_d[blk] = pg;
    end
    if (erase_en) begin
      hiv_d[erase_blk] = 1'b0;
      for (int p = 0; p < PAGES_PER_BLOCK; p++) begin
        cnt_d[int'(erase_blk) * PAGES_PER_BLOCK + p] = 3'd0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL_PAGES; i++) cnt_q[i] <= 3'd0;
      for (int b = 0; b < NUM_BLOCKS; b++) begin
        hiv_q[b] <= 1'b0;
        hip_q[b] <= '0;
      end
    end else if (commit_en | erase_en) begin
      cnt_q <= cnt_d;
      hiv_q <= hiv_d;
      hip_q <= hip_d;
    end
  end

  // R5
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |-> (cnt_q[row] < SLC_LIMIT));

  // R6
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_en |=> !hiv_q[$past(erase_blk)]);

  // R4
  ptr_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_en |=> (hiv_q[$past(blk)] && (hip_q[$past(blk)] == $past(pg))));

endmodule

// File: rtl/fe_flash_emu.sv
module fe_flash_emu
  import fe_pkg::*;
#(
  parameter int NUM_BLOCKS      = 4,
  parameter int PAGES_PER_BLOCK = 32,
  parameter int DATA_BYTES      = 512,
  parameter int SPARE_BYTES     = 16,
  localparam int TOTAL_PAGES    = NUM_BLOCKS * PAGES_PER_BLOCK,
  localparam int ROW_AW         = $clog2(TOTAL_PAGES),
  localparam int ADDR_W         = ROW_AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mlc_mode,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              wr_valid,
  input  logic [7:0]        wr_byte,
  output logic              rd_valid,
  output logic [7:0]        rd_byte,
  output logic              done,
  output logic [1:0]        status
);

  localparam int PAGE_BYTES = DATA_BYTES + SPARE_BYTES;
  localparam int PAGE_BITS  = PAGE_BYTES * 8;
  localparam int IDX_W      = $clog2(PAGE_BYTES);
  localparam int BLK_AW     = $clog2(NUM_BLOCKS);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PAGE_BYTES - 1);

  fe_state_e         state_q, state_d;
  fe_status_e        status_q, status_d;
  fe_status_e        verdict;
  logic [ROW_AW-1:0] row_q;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              accept, in_range, row_en, idx_en, status_en;
  logic              arr_wr_en, erase_en, buf_load_en, buf_byte_en;
  logic [PAGE_BITS-1:0] arr_rd_word, buf_word;

  assign accept   = (state_q == S_IDLE) && cmd_valid;
  assign in_range = cmd_addr < ADDR_W'(TOTAL_PAGES);

  always_comb begin
    state_d = state_q;
    case (state_q)
      S_IDLE: begin
        if (cmd_valid) begin
          if (!in_range)      state_d = S_DONE;
          else if (cmd_op[1]) state_d = S_ERASE;
          else if (cmd_op[0]) state_d = S_LOAD;
          else                state_d = S_RD_FETCH;
        end
      end
      S_RD_FETCH: state_d = S_RD_OUT;
      S_RD_OUT:   if (idx_q == LAST_IDX) state_d = S_DONE;
      S_LOAD:     if (wr_valid && idx_q == LAST_IDX) state_d = S_COMMIT;
      S_COMMIT:   state_d = S_DONE;
      S_ERASE:    state_d = S_DONE;
      S_DONE:     state_d = S_IDLE;
      default:    state_d = S_IDLE;
    endcase
  end

  always_comb begin
    idx_en = 1'b0;
    idx_d  = idx_q;
    if (state_q == S_IDLE) begin
      idx_en = 1'b1;
      idx_d  = '0;
    end else if ((state_q == S_RD_OUT) || (state_q == S_LOAD && wr_valid)) begin
      idx_en = 1'b1;
      idx_d  = idx_q + 1'b1;
    end
  end

  always_comb begin
    status_en = 1'b0;
    status_d  = status_q;
    if (accept) begin
      status_en = 1'b1;
      status_d  = in_range ? ST_OK : ST_RANGE;
    end else if (state_q == S_COMMIT) begin
      status_en = 1'b1;
      status_d  = verdict;
    end
  end

  assign row_en = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= S_IDLE;
      status_q <= ST_OK;
      row_q    <= '0;
      idx_q    <= '0;
    end else begin
      state_q <= state_d;
      if (status_en) status_q <= status_d;
      if (row_en)    row_q    <= cmd_addr[ROW_AW-1:0];
      if (idx_en)    idx_q    <= idx_d;
    end
  end

  assign arr_wr_en   = (state_q == S_COMMIT) && (verdict == ST_OK);
  assign erase_en    = (state_q == S_ERASE);
  assign buf_load_en = (state_q == S_RD_FETCH);
  assign buf_byte_en = (state_q == S_LOAD) && wr_valid;

  fe_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk       (clk),
    .load_en   (buf_load_en),
    .load_word (arr_rd_word),
    .byte_en   (buf_byte_en),
    .byte_idx  (idx_q),
    .byte_in   (wr_byte),
    .word      (buf_word),
    .byte_out  (rd_byte)
  );

  fe_page_store #(
    .NUM_BLOCKS      (NUM_BLOCKS),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .PAGE_BITS       (PAGE_BITS)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr   (row_q),
    .rd_word   (arr_rd_word),
    .wr_en     (arr_wr_en),
    .wr_addr   (row_q),
    .wr_word   (buf_word),
    .erase_en  (erase_en),
    .erase_blk (row_q[ROW_AW-1 -: BLK_AW])
  );

  fe_rule_check #(
    .NUM_BLOCKS      (NUM_BLOCKS),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK)
  ) u_rules (
    .clk       (clk),
    .rst_n     (rst_n),
    .mlc_mode  (mlc_mode),
    .row       (row_q),
    .verdict   (verdict),
    .commit_en (arr_wr_en),
    .erase_en  (erase_en),
    .erase_blk (row_q[ROW_AW-1 -: BLK_AW])
  );

  assign cmd_ready = (state_q == S_IDLE);
  assign rd_valid  = (state_q == S_RD_OUT);
  assign done      = (state_q == S_DONE);
  assign status    = status_q;

  // R7
  range_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_ready && cmd_valid && (cmd_addr >= ADDR_W'(TOTAL_PAGES)))
      |=> (done && status == ST_RANGE));

  // R8
  stream_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_valid) |-> done);

  // R4
  reject_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (status == ST_ORDER || status == ST_LIMIT)) |-> !$past(arr_wr_en));

  // R8
  ready_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_ready) |-> $past(done));

endmodule

// File: tb/sim_fe_flash_emu.sv
module sim_fe_flash_emu;

  localparam int CLK_PERIOD = 10;
  localparam int NB   = 4;
  localparam int PPB  = 32;
  localparam int DB   = 512;
  localparam int SB   = 16;
  localparam int PB   = DB + SB;
  localparam int TOT  = NB * PPB;
  localparam int AW   = $clog2(TOT) + 1;
  localparam int WD_LIMIT = 190000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          mlc_mode = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [1:0]    cmd_op = 2'd0;
  logic [AW-1:0] cmd_addr = '0;
  logic          wr_valid = 1'b0;
  logic [7:0]    wr_byte = 8'd0;
  logic          rd_valid;
  logic [7:0]    rd_byte;
  logic          done;
  logic [1:0]    status;

  fe_flash_emu #(
    .NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PPB), .DATA_BYTES(DB), .SPARE_BYTES(SB)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .mlc_mode(mlc_mode),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .rd_valid(rd_valid), .rd_byte(rd_byte), .done(done), .status(status)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  int wd_cnt   = 0;

  // bench model
  int m_cnt   [TOT];
  int m_seed  [TOT][4];
  bit m_hiv   [NB];
  int m_hip   [NB];

  always @(posedge clk) begin
    wd_cnt++;
    if (wd_cnt > WD_LIMIT) begin
      n_checks++;
      n_fails++;
      $display("FAIL R8 watchdog expired: actual %0d cycles, expected at most %0d", wd_cnt, WD_LIMIT);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  function automatic logic [7:0] pat(int seed, int i);
    logic [31:0] h;
    h = (seed * 32'd2654435761) ^ (i * 32'd40503) ^ 32'h5bd1e995;
    h = h ^ (h >> 13);
    h = h * 32'd1274126177;
    return h[15:8] | h[23:16] | 8'h00;
  endfunction

  function automatic logic [7:0] exp_byte(int row, int i);
    logic [7:0] b = 8'hFF;
    for (int k = 0; k < m_cnt[row]; k++) b &= pat(m_seed[row][k], i);
    return b;
  endfunction

  function automatic int exp_status(int op, int addr);
    int blk, pg, lim;
    if (addr >= TOT) return 3;
    if (op != 1) return 0;
    blk = addr / PPB;
    pg  = addr % PPB;
    lim = mlc_mode ? 1 : 4;
    if (m_hiv[blk] && pg < m_hip[blk]) return 1;
    if (m_cnt[addr] >= lim) return 2;
    return 0;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // issue one command, check status, timing and any read data against the model
  task automatic run(int op, int addr, int seed, string req);
    int cyc, nbytes, first_rd, done_cyc, bad, bad_i, bad_a, bad_e, est, exp_done;
    bit got;
    while (!cmd_ready) @(negedge clk);
    est = exp_status(op, addr);
    cmd_valid = 1'b1;
    cmd_op    = op[1:0];
    cmd_addr  = addr[AW-1:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    cyc = 1;
    if (op == 1 && addr < TOT) begin
      for (int i = 0; i < PB; i++) begin
        wr_valid = 1'b1;
        wr_byte  = pat(seed, i);
        @(negedge clk);
        cyc++;
      end
      wr_valid = 1'b0;
    end
    nbytes = 0; first_rd = -1; done_cyc = -1; bad = 0; bad_i = 0; bad_a = 0; bad_e = 0;
    got = 1'b0;
    while (!got && cyc < PB + 20) begin
      if (rd_valid) begin
        if (first_rd < 0) first_rd = cyc;
        if (addr < TOT && nbytes < PB && rd_byte !== exp_byte(addr, nbytes)) begin
          if (bad == 0) begin
            bad_i = nbytes; bad_a = rd_byte; bad_e = exp_byte(addr, nbytes);
          end
          bad++;
        end
        nbytes++;
      end
      if (done) begin
        got = 1'b1;
        done_cyc = cyc;
        check(status == est[1:0], req, status, est);
      end else begin
        @(negedge clk);
        cyc++;
      end
    end
    if (addr >= TOT)       exp_done = 1;
    else if (op >= 2)      exp_done = 2;
    else if (op == 1)      exp_done = PB + 2;
    else                   exp_done = PB + 2;
    check(done_cyc == exp_done, "R8 done timing", done_cyc, exp_done);
    if (op == 0 && addr < TOT) begin
      check(nbytes == PB && first_rd == 2, "R8 read stream length", nbytes, PB);
      if (bad != 0) $display("  first bad byte index %0d", bad_i);
      check(bad == 0, {req, " read data"}, bad_a, bad_e);
    end else begin
      check(nbytes == 0, "R7/R8 no read stream", nbytes, 0);
    end
    // model update
    if (addr < TOT && est == 0) begin
      if (op == 1) begin
        m_seed[addr][m_cnt[addr]] = seed;
        m_cnt[addr]++;
        m_hiv[addr / PPB] = 1'b1;
        m_hip[addr / PPB] = addr % PPB;
      end else if (op >= 2) begin
        for (int p = 0; p < PPB; p++) m_cnt[(addr / PPB) * PPB + p] = 0;
        m_hiv[addr / PPB] = 1'b0;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    for (int r = 0; r < TOT; r++) m_cnt[r] = 0;
    for (int b = 0; b < NB; b++) begin m_hiv[b] = 1'b0; m_hip[b] = 0; end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // reset state
    check(cmd_ready == 1'b0 || cmd_ready == 1'b1, "R1 reset ready known", cmd_ready, 0);
    check(done == 1'b0 && rd_valid == 1'b0, "R1 reset outputs", {done, rd_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(cmd_ready == 1'b1, "R8 ready when idle", cmd_ready, 1);
    run(0, 0, 0, "R1 erased page 0");
    run(0, TOT - 1, 0, "R1 erased last page");

    // program, AND accumulation
    run(1, 5, 11, "R2 first program");
    run(0, 5, 0, "R2 read after program");
    run(1, 5, 22, "R2 second program same page");
    run(0, 5, 0, "R2 AND of two programs");

    // ordering: page 7 then page 6 is refused, page 6 unchanged
    run(1, 7, 33, "R4 higher page allowed");
    run(1, 6, 44, "R4 lower page refused");
    run(0, 6, 0, "R4 refused page unchanged");
    // count limit in 4-program mode on page 7
    run(1, 7, 55, "R5 slc program 2");
    run(1, 7, 66, "R5 slc program 3");
    run(1, 7, 77, "R5 slc program 4");
    run(1, 7, 88, "R5 slc program 5 refused");
    run(0, 7, 0, "R5 page after refusal");

    // erase block 0, block 1 untouched
    run(1, PPB + 2, 99, "R3 program other block");
    run(2, 3, 0, "R3 erase block 0");
    run(0, 5, 0, "R3 block 0 page erased");
    run(0, 7, 0, "R3 block 0 spare erased");
    run(0, PPB + 2, 0, "R3 other block kept");
    // erase resets counts and pointer
    run(1, 7, 101, "R6 program after erase");
    run(1, 0, 102, "R6 lower page after erase refused by new pointer");
    run(3, 1, 0, "R6 erase via code 3");
    run(1, 0, 103, "R6 page 0 after second erase");

    // single-program mode and priority
    mlc_mode = 1'b1;
    run(1, 0, 104, "R5 mlc second program refused");
    run(1, 2 * PPB + 3, 105, "R9 setup page 3");
    run(1, 2 * PPB + 4, 106, "R9 setup page 4");
    run(1, 2 * PPB + 3, 107, "R9 order beats limit");
    run(0, 2 * PPB + 3, 0, "R9 page kept");
    mlc_mode = 1'b0;

    // out of range for every op
    run(0, TOT, 0, "R7 read out of range");
    run(1, TOT + 9, 0, "R7 program out of range");
    run(2, (1 << (AW - 1)) + 40, 0, "R7 erase out of range");
    run(0, 2 * PPB + 4, 0, "R7 state unchanged");

    // constrained random over blocks 2 and 3
    for (int n = 0; n < 60; n++) begin
      int sel, addr;
      sel  = $urandom_range(0, 99);
      addr = 2 * PPB + $urandom_range(0, 2 * PPB - 1);
      if ($urandom_range(0, 9) == 0) mlc_mode = ~mlc_mode;
      if (sel < 45)      run(1, addr, $urandom, "R2/R4/R5 random program");
      else if (sel < 82) run(0, addr, 0, "R2 random read");
      else if (sel < 92) run(2, addr, 0, "R3/R6 random erase");
      else               run($urandom_range(0, 3), TOT + $urandom_range(0, TOT - 1), 0, "R7 random range");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule